// File: doc/BRIEF.md
# Debug Extension Register File

This block is the per-device register file that a debug fabric uses to configure a device and inspect it. It spans 256 sixteen-bit slots behind one access port. A request carries a device ID, an 8-bit register index, a write flag and write data. The block acts only on requests whose ID matches its own. A read returns its data on the cycle after the request. A write either commits in full or is rejected in full, and a rejected write raises an error pulse on the same cycle a read would have answered.

Slots 0x00 to 0x0F have fixed meanings: identity, latched power-on configuration, model and version, live status, the event-selection window with its flag port, the monitor vector, and the read-only view of the last captured event. Slots from 0x10 upward hold a small scratch store whose depth is a parameter. Every other slot reads as zero and refuses writes. The device ID and the configuration straps are sampled once, as reset ends, and are driven out so that the rest of the device can read its mode bits. The logic that decides how an event is handled sits outside this block. This block only carries the selection and the flag traffic for it.

Top module: `dbg_regfile`

## Requirements
- R1: A request whose `acc_dev` differs from the latched device ID gives no `rd_valid`, no `wr_err` and no `ev_wr_en`, and changes no register.
- R2: An accepted read drives `rd_valid` high with `rd_data` for exactly the cycle after the request. Reserved bits read 0. Slots 0x05, 0x06, 0x07, 0x0B, and every slot at or above 0x10 plus `SCRATCH_WORDS`, read 0x0000.
- R3: Slot 0x00 reads the latched device ID in bits 3:0. Slot 0x02 reads `MODEL`. Slot 0x03 reads `VER_MAJOR` in bits 15:8 and `VER_MINOR` in bits 7:0.
- R4: `strap_id` and `strap_cfg` are sampled on the first clock edge with `rst_n` high and are held until the next reset. Slot 0x01 and `cfg_word` show the configuration with this layout: boot device in bits 1:0 (00 boot ROM, 01 card, 10 cartridge-port device, 11 expansion-port device), bus-hold type in bit 2, export region in bit 3, handheld mode in bit 4, power-on suspended in bit 5, power-on monitor mode in bit 6, self-test code in bits 15:12 (zero means pass). Bits 11:7 are reserved.
- R5: Slot 0x04 reads the live status: bit 0 suspended, bit 1 monitor mode, bit 2 shutdown, bit 3 enabled, bit 4 monitor-silent-set, bit 5 compatible-silent-set.
- R6: Slot 0x08 bits 7:0 form a read/write event selector, driven on `ev_sel`. Slot 0x09 reads `ev_flags_in` masked to bits 4:0 (bit 0 suspend, bit 1 monitor, bit 2 shutdown, bit 3 monitor-silent, bit 4 compatible-silent). An accepted write to slot 0x09 pulses `ev_wr_en` for one cycle, on the cycle after the request, with the data on `ev_wr_data`.
- R7: A write that sets a reserved bit, or that changes any read-only bit, is discarded whole and pulses `wr_err` on the cycle after the request. A write to a read-only slot that equals its current contents is accepted without error and has no effect.
- R8: Any write to slot 0x05, 0x06, 0x07 or 0x0B, or to a slot outside the fixed range and outside the scratch range, raises `wr_err`.
- R9: While `st_enabled` is 0 or `st_shutdown` is 1, only requests with `acc_sysmsg` high are answered. Other requests give no response and change nothing.
- R10: Slot 0x0A is a full 16-bit read/write monitor vector, driven on `mon_vector`.
- R11: Slots 0x0C, 0x0D, 0x0E and 0x0F are read-only views of `cap_code` (bits 7:0), `cap_addr`, `cap_data` and `cap_flags`.
- R12: Slots 0x10 through 0x10 plus `SCRATCH_WORDS` minus 1 are read/write scratch words, and reset clears them to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_id | input | 4 | Device ID strap, sampled as reset ends |
| strap_cfg | input | 16 | Configuration straps, sampled as reset ends |
| acc_req | input | 1 | Access request |
| acc_sysmsg | input | 1 | Request is a system-message transaction |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_dev | input | 4 | Target device ID |
| acc_idx | input | 8 | Register slot index |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 16 | Read data |
| wr_err | output | 1 | Write rejected, one cycle after the request |
| st_suspended | input | 1 | Device suspended |
| st_monitor | input | 1 | Device in monitor mode |
| st_shutdown | input | 1 | Device shut down |
| st_enabled | input | 1 | Device enabled |
| st_mon_silent | input | 1 | Some monitor-silent flag is set |
| st_cmp_silent | input | 1 | Some compatible-silent flag is set |
| ev_flags_in | input | 16 | Flags of the selected event, from the event table |
| ev_sel | output | 8 | Selected event code |
| ev_wr_en | output | 1 | Flag write strobe toward the event table |
| ev_wr_data | output | 16 | Flag write data |
| mon_vector | output | 16 | Monitor handler address |
| cap_code | input | 8 | Code of the last captured event |
| cap_addr | input | 16 | Address of the last captured event |
| cap_data | input | 16 | Data of the last captured event |
| cap_flags | input | 16 | Flags of the last captured event |
| dev_id | output | 4 | Latched device ID |
| cfg_word | output | 16 | Latched power-on configuration |

## Verification
A wrong attribute for a slot shows up as a write error on a write that should be legal, or as a missing error on an illegal one. It appears one cycle after the request, and readback on the next access confirms whether the state moved. A strap latch that keeps sampling after reset shows as a changed slot 0x01 or `cfg_word` as soon as the straps toggle. A wrong ID or gating decision shows as an answer that appears, or fails to appear, on the cycle after the request. A corrupted scratch or vector register is visible on the next read of that slot or directly on `mon_vector`.

// File: rtl/dbg_regfile_pkg.sv
// Package: shared widths, slot indices, bit masks and the per-slot access
// attributes of the debug extension register file.
// Assumes slot indices are 8 bits and register words are 16 bits.
package dbg_regfile_pkg;

    localparam int IDX_W  = 8;
    localparam int WORD_W = 16;
    localparam int ID_W   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t IX_ID    = 8'h00;
    localparam idx_t IX_CFG   = 8'h01;
    localparam idx_t IX_MODEL = 8'h02;
    localparam idx_t IX_VER   = 8'h03;
    localparam idx_t IX_STAT  = 8'h04;
    localparam idx_t IX_EVSEL = 8'h08;
    localparam idx_t IX_EVFLG = 8'h09;
    localparam idx_t IX_MVEC  = 8'h0A;
    localparam idx_t IX_CCODE = 8'h0C;
    localparam idx_t IX_CADDR = 8'h0D;
    localparam idx_t IX_CDATA = 8'h0E;
    localparam idx_t IX_CFLG  = 8'h0F;
    localparam idx_t IX_USER  = 8'h10;

    // Defined bits of the configuration, status and event-flag words.
    localparam word_t CFG_MASK   = 16'hF07F;
    localparam word_t STAT_MASK  = 16'h003F;
    localparam word_t EVFLG_MASK = 16'h001F;

    // Access attributes of one slot: read-only bits, writable bits, and
    // whether every write to the slot is refused.
    typedef struct packed {
        word_t ro;
        word_t rw;
        logic  locked;
    } slot_attr_t;

    // Attribute lookup; user_hit marks an index inside the scratch range.
    function automatic slot_attr_t attr_of(input idx_t idx, input logic user_hit);
        slot_attr_t a;
        a = '{ro: 16'h0000, rw: 16'h0000, locked: 1'b0};
        case (idx)
            IX_ID:    a.ro = 16'h000F;
            IX_CFG:   a.ro = CFG_MASK;
            IX_MODEL: a.ro = 16'hFFFF;
            IX_VER:   a.ro = 16'hFFFF;
            IX_STAT:  a.ro = STAT_MASK;
            IX_EVSEL: a.rw = 16'h00FF;
            IX_EVFLG: a.rw = EVFLG_MASK;
            IX_MVEC:  a.rw = 16'hFFFF;
            IX_CCODE: a.ro = 16'h00FF;
            IX_CADDR: a.ro = 16'hFFFF;
            IX_CDATA: a.ro = 16'hFFFF;
            IX_CFLG:  a.ro = 16'hFFFF;
            default: begin
                if (user_hit) a.rw = 16'hFFFF;
                else          a.locked = 1'b1;
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dbg_strap_latch.sv
// Module: captures the device ID and configuration straps on the first
// clock edge after reset is released, then holds them until the next reset.
// Assumes the straps are stable around that edge. Reserved strap bits are
// dropped at capture.
module dbg_strap_latch
    import dbg_regfile_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] strap_id,
    input  word_t           strap_cfg,
    output logic [ID_W-1:0] id_q,
    output word_t           cfg_q,
    output logic            pending
);

    // One-shot capture of the straps as reset ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b1;
            id_q    <= '0;
            cfg_q   <= '0;
        end else if (pending) begin
            pending <= 1'b0;
            id_q    <= strap_id;
            cfg_q   <= strap_cfg & CFG_MASK;
        end
    end

    // R4: once captured, the straps never move again before the next reset.
    a_r4_straps_held: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> ($stable(cfg_q) && $stable(id_q) && !pending));

endmodule

// File: rtl/dbg_write_check.sv
// Module: decides whether a write to one slot may commit. Refuses the whole
// write if it sets a reserved bit, changes a read-only bit, or targets a
// locked slot. Also supplies the read mask that zeroes reserved bits.
// Assumes cur is the slot's present contents.
module dbg_write_check
    import dbg_regfile_pkg::*;
(
    input  idx_t  idx,
    input  logic  user_hit,
    input  word_t wdata,
    input  word_t cur,
    output logic  wr_ok,
    output word_t rd_mask
);

    slot_attr_t attr;
    word_t      resv;

    // Per-slot legality of the offered write data.
    always_comb begin
        attr    = attr_of(idx, user_hit);
        resv    = ~(attr.ro | attr.rw);
        rd_mask = attr.ro | attr.rw;
        wr_ok   = !attr.locked
                  && ((wdata & resv) == '0)
                  && (((wdata ^ cur) & attr.ro) == '0);
    end

endmodule

// File: rtl/dbg_scratch.sv
// Module: device-specific scratch words behind the fixed slots. Each word is
// its own register, and reset clears all of them.
// Assumes WORDS is at most 240. Offsets at or above WORDS read zero.
module dbg_scratch
    import dbg_regfile_pkg::*;
#(
    parameter int WORDS = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  idx_t  off,
    input  word_t wdata,
    output word_t rdata
);

    localparam int FLAT_W = WORDS * WORD_W;

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        word_t word_q;
        // Holds one scratch word.
        always_ff @(posedge clk) begin
            if (!rst_n)                     word_q <= '0;
            else if (we && off == idx_t'(g)) word_q <= wdata;
        end
        assign flat[g*WORD_W +: WORD_W] = word_q;
    end

    // Read mux over the scratch words.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (off == idx_t'(i)) rdata = flat[i*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/dbg_regfile.sv
// Module: top of the debug extension register file. It filters requests by
// device ID and by the enable and shutdown gating, muxes the 256 slots,
// applies the all-or-nothing write rule, and registers every response one
// cycle after its request.
// Assumes at most one request per cycle. Requests made while the straps are
// still uncaptured are dropped.
module dbg_regfile
    import dbg_regfile_pkg::*;
#(
    parameter int          SCRATCH_WORDS = 16,
    parameter logic [15:0] MODEL         = 16'h5A21,
    parameter logic [7:0]  VER_MAJOR     = 8'd1,
    parameter logic [7:0]  VER_MINOR     = 8'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  strap_id,
    input  logic [15:0] strap_cfg,
    input  logic        acc_req,
    input  logic        acc_sysmsg,
    input  logic        acc_we,
    input  logic [3:0]  acc_dev,
    input  logic [7:0]  acc_idx,
    input  logic [15:0] acc_wdata,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        wr_err,
    input  logic        st_suspended,
    input  logic        st_monitor,
    input  logic        st_shutdown,
    input  logic        st_enabled,
    input  logic        st_mon_silent,
    input  logic        st_cmp_silent,
    input  logic [15:0] ev_flags_in,
    output logic [7:0]  ev_sel,
    output logic        ev_wr_en,
    output logic [15:0] ev_wr_data,
    output logic [15:0] mon_vector,
    input  logic [7:0]  cap_code,
    input  logic [15:0] cap_addr,
    input  logic [15:0] cap_data,
    input  logic [15:0] cap_flags,
    output logic [3:0]  dev_id,
    output logic [15:0] cfg_word
);

    localparam int USER_END = int'(IX_USER) + SCRATCH_WORDS;

    logic  pending;
    logic  gate_ok, hit, user_hit, wr_ok, wr_take, wr_refuse;
    word_t raw, cur, rd_mask, scr_rdata;
    idx_t  user_off;
    logic [7:0] ev_sel_q;
    word_t mvec_q;

    dbg_strap_latch u_straps (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_id (strap_id),
        .strap_cfg(strap_cfg),
        .id_q     (dev_id),
        .cfg_q    (cfg_word),
        .pending  (pending)
    );

    // Request filtering: ID match, capture done, and enable/shutdown gating.
    always_comb begin
        gate_ok  = acc_sysmsg || (st_enabled && !st_shutdown);
        hit      = acc_req && !pending && (acc_dev == dev_id) && gate_ok;
        user_hit = (int'(acc_idx) >= int'(IX_USER)) && (int'(acc_idx) < USER_END);
        user_off = acc_idx - IX_USER;
    end

    dbg_scratch #(.WORDS(SCRATCH_WORDS)) u_scratch (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_take && user_hit),
        .off  (user_off),
        .wdata(acc_wdata),
        .rdata(scr_rdata)
    );

    // Raw slot contents before reserved-bit masking.
    always_comb begin
        case (acc_idx)
            IX_ID:    raw = {12'h000, dev_id};
            IX_CFG:   raw = cfg_word;
            IX_MODEL: raw = MODEL;
            IX_VER:   raw = {VER_MAJOR, VER_MINOR};
            IX_STAT:  raw = {10'h000, st_cmp_silent, st_mon_silent, st_enabled,
                             st_shutdown, st_monitor, st_suspended};
            IX_EVSEL: raw = {8'h00, ev_sel_q};
            IX_EVFLG: raw = ev_flags_in;
            IX_MVEC:  raw = mvec_q;
            IX_CCODE: raw = {8'h00, cap_code};
            IX_CADDR: raw = cap_addr;
            IX_CDATA: raw = cap_data;
            IX_CFLG:  raw = cap_flags;
            default:  raw = user_hit ? scr_rdata : '0;
        endcase
    end

    dbg_write_check u_check (
        .idx     (acc_idx),
        .user_hit(user_hit),
        .wdata   (acc_wdata),
        .cur     (cur),
        .wr_ok   (wr_ok),
        .rd_mask (rd_mask)
    );

    // Masked contents and the commit decision for a write.
    always_comb begin
        cur       = raw & rd_mask;
        wr_take   = hit && acc_we && wr_ok;
        wr_refuse = hit && acc_we && !wr_ok;
    end

    // Registered responses, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            wr_err     <= 1'b0;
            ev_wr_en   <= 1'b0;
            ev_wr_data <= '0;
        end else begin
            rd_valid   <= hit && !acc_we;
            rd_data    <= (hit && !acc_we) ? cur : '0;
            wr_err     <= wr_refuse;
            ev_wr_en   <= wr_take && (acc_idx == IX_EVFLG);
            ev_wr_data <= (wr_take && (acc_idx == IX_EVFLG)) ? acc_wdata : '0;
        end
    end

    // Writable fixed slots: event selector and monitor vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_sel_q <= '0;
            mvec_q   <= '0;
        end else if (wr_take) begin
            if (acc_idx == IX_EVSEL) ev_sel_q <= acc_wdata[7:0];
            if (acc_idx == IX_MVEC)  mvec_q   <= acc_wdata;
        end
    end

    assign ev_sel     = ev_sel_q;
    assign mon_vector = mvec_q;

    // R1: a request for another device ID produces nothing.
    a_r1_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_dev != dev_id) |=> (!rd_valid && !wr_err && !ev_wr_en));

    // R2: read data and write error never appear together.
    a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_err}));

    // R2: reserved slots read as zero.
    a_r2_resv_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(acc_idx) == 8'h05 || $past(acc_idx) == 8'h06 ||
                      $past(acc_idx) == 8'h07 || $past(acc_idx) == 8'h0B))
        |-> (rd_data == 16'h0000));

    // R6: flag writes reaching the event table carry no reserved bits.
    a_r6_flags_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_en |-> (((ev_wr_data & ~EVFLG_MASK) == '0) && !wr_err));

    // R7: a refused write leaves the writable slots untouched.
    a_r7_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($stable(ev_sel_q) && $stable(mvec_q)));

    // R9: a gated device answers only system messages.
    a_r9_gated_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_sysmsg && (st_shutdown || !st_enabled))
        |=> (!rd_valid && !wr_err && !ev_wr_en));

endmodule

// File: tb/tb_dbg_regfile.sv
// Bench: walks a table of access vectors, then runs directed tests for reset,
// strap holding, ID filtering, gating, the flag port and live status.
module tb_dbg_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_id = 4'h6;
    logic [15:0] strap_cfg = 16'hA8D5;
    logic        acc_req = 1'b0, acc_sysmsg = 1'b0, acc_we = 1'b0;
    logic [3:0]  acc_dev = 4'h0;
    logic [7:0]  acc_idx = 8'h00;
    logic [15:0] acc_wdata = 16'h0000;
    logic        rd_valid, wr_err, ev_wr_en;
    logic [15:0] rd_data, ev_wr_data, mon_vector, cfg_word, ev_flags_in;
    logic [7:0]  ev_sel;
    logic [3:0]  dev_id;
    logic        st_suspended = 1'b1, st_monitor = 1'b0, st_shutdown = 1'b0;
    logic        st_enabled = 1'b1, st_mon_silent = 1'b1, st_cmp_silent = 1'b0;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic g_valid, g_err, g_evwr;
    logic [15:0] g_data, g_evdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Event table stand-in: upper bits set to test masking.
    assign ev_flags_in = {8'hE0, 3'b000, ev_sel[4:0]};

    dbg_regfile dut (
        .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .strap_cfg(strap_cfg),
        .acc_req(acc_req), .acc_sysmsg(acc_sysmsg), .acc_we(acc_we),
        .acc_dev(acc_dev), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_err(wr_err),
        .st_suspended(st_suspended), .st_monitor(st_monitor),
        .st_shutdown(st_shutdown), .st_enabled(st_enabled),
        .st_mon_silent(st_mon_silent), .st_cmp_silent(st_cmp_silent),
        .ev_flags_in(ev_flags_in), .ev_sel(ev_sel), .ev_wr_en(ev_wr_en),
        .ev_wr_data(ev_wr_data), .mon_vector(mon_vector),
        .cap_code(8'h3C), .cap_addr(16'hBEEF), .cap_data(16'h1234),
        .cap_flags(16'h8001), .dev_id(dev_id), .cfg_word(cfg_word)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  idx;
        logic [15:0] wd;
        logic        err;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 16'h0000, 1'b0, 16'h0006, 4'd3},  // R3 device ID
        '{1'b0, 8'h01, 16'h0000, 1'b0, 16'hA055, 4'd4},  // R4 config, reserved masked
        '{1'b0, 8'h02, 16'h0000, 1'b0, 16'h5A21, 4'd3},  // R3 model
        '{1'b0, 8'h03, 16'h0000, 1'b0, 16'h0104, 4'd3},  // R3 version
        '{1'b0, 8'h04, 16'h0000, 1'b0, 16'h0019, 4'd5},  // R5 status
        '{1'b0, 8'h0C, 16'h0000, 1'b0, 16'h003C, 4'd11}, // R11 code
        '{1'b0, 8'h0D, 16'h0000, 1'b0, 16'hBEEF, 4'd11}, // R11 address
        '{1'b0, 8'h0E, 16'h0000, 1'b0, 16'h1234, 4'd11}, // R11 data
        '{1'b0, 8'h0F, 16'h0000, 1'b0, 16'h8001, 4'd11}, // R11 flags
        '{1'b0, 8'h05, 16'h0000, 1'b0, 16'h0000, 4'd2},  // R2 reserved slot
        '{1'b0, 8'h0B, 16'h0000, 1'b0, 16'h0000, 4'd2},  // R2 reserved slot
        '{1'b0, 8'h20, 16'h0000, 1'b0, 16'h0000, 4'd2},  // R2 unimplemented slot
        '{1'b1, 8'h0A, 16'hC0DE, 1'b0, 16'h0000, 4'd10}, // R10 write vector
        '{1'b0, 8'h0A, 16'h0000, 1'b0, 16'hC0DE, 4'd10}, // R10 read back
        '{1'b1, 8'h08, 16'h0057, 1'b0, 16'h0000, 4'd6},  // R6 select event
        '{1'b0, 8'h08, 16'h0000, 1'b0, 16'h0057, 4'd6},  // R6 read selector
        '{1'b0, 8'h09, 16'h0000, 1'b0, 16'h0017, 4'd6},  // R6 flags masked
        '{1'b1, 8'h08, 16'h0157, 1'b1, 16'h0000, 4'd7},  // R7 reserved bit set
        '{1'b0, 8'h08, 16'h0000, 1'b0, 16'h0057, 4'd7},  // R7 selector unchanged
        '{1'b1, 8'h00, 16'h0007, 1'b1, 16'h0000, 4'd7},  // R7 change read-only ID
        '{1'b1, 8'h00, 16'h0006, 1'b0, 16'h0000, 4'd7},  // R7 same value accepted
        '{1'b1, 8'h01, 16'hA055, 1'b0, 16'h0000, 4'd7},  // R7 same config accepted
        '{1'b1, 8'h01, 16'hA0D5, 1'b1, 16'h0000, 4'd7},  // R7 reserved config bit
        '{1'b1, 8'h05, 16'h0000, 1'b1, 16'h0000, 4'd8},  // R8 slot 5
        '{1'b1, 8'h0B, 16'h0000, 1'b1, 16'h0000, 4'd8},  // R8 slot 0x0B
        '{1'b1, 8'h20, 16'h0001, 1'b1, 16'h0000, 4'd8},  // R8 past scratch
        '{1'b1, 8'h10, 16'h1111, 1'b0, 16'h0000, 4'd12}, // R12 first word
        '{1'b1, 8'h1F, 16'hFFFF, 1'b0, 16'h0000, 4'd12}, // R12 last word
        '{1'b0, 8'h10, 16'h0000, 1'b0, 16'h1111, 4'd12}, // R12 read first
        '{1'b0, 8'h1F, 16'h0000, 1'b0, 16'hFFFF, 4'd12}, // R12 read last
        '{1'b0, 8'h11, 16'h0000, 1'b0, 16'h0000, 4'd12}  // R12 untouched word
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One access; outputs are sampled 1 time unit after the responding edge.
    task automatic access(input logic we, input logic [3:0] dev, input logic [7:0] idx,
                          input logic [15:0] wd, input logic sys);
        @(negedge clk);
        acc_req = 1'b1; acc_we = we; acc_dev = dev; acc_idx = idx;
        acc_wdata = wd; acc_sysmsg = sys;
        @(posedge clk);
        #1;
        g_valid = rd_valid; g_data = rd_data; g_err = wr_err;
        g_evwr = ev_wr_en; g_evdata = ev_wr_data;
        acc_req = 1'b0; acc_we = 1'b0; acc_sysmsg = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        strap_cfg = 16'h0000;   // R4: later strap changes must not be seen
        strap_id  = 4'h2;

        // Reset state
        access(1'b0, 4'h6, 8'h08, 16'h0, 1'b0); chk("R6 reset selector", g_data, 16'h0000);
        access(1'b0, 4'h6, 8'h0A, 16'h0, 1'b0); chk("R10 reset vector", g_data, 16'h0000);
        access(1'b0, 4'h6, 8'h10, 16'h0, 1'b0); chk("R12 reset scratch", g_data, 16'h0000);
        chk("R4 cfg_word held", cfg_word, 16'hA055);
        chk("R4 dev_id held", {12'h0, dev_id}, 16'h0006);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, 4'h6, VEC[i].idx, VEC[i].wd, 1'b0);
            checks++;
            if (VEC[i].we) begin
                if (g_err !== VEC[i].err || g_valid !== 1'b0) begin
                    errors++;
                    $display("FAIL R%0d vec %0d: err %b valid %b expected err %b",
                             VEC[i].req, i, g_err, g_valid, VEC[i].err);
                end
            end else if (g_valid !== 1'b1 || g_data !== VEC[i].exp) begin
                errors++;
                $display("FAIL R%0d vec %0d: valid %b data %h expected %h",
                         VEC[i].req, i, g_valid, g_data, VEC[i].exp);
            end
        end
        chk("R10 mon_vector port", mon_vector, 16'hC0DE);
        chk("R6 ev_sel port", {8'h0, ev_sel}, 16'h0057);

        // R1: foreign ID ignored
        access(1'b0, 4'h5, 8'h00, 16'h0, 1'b0); chk("R1 foreign read", {15'h0, g_valid}, 16'h0);
        access(1'b1, 4'h5, 8'h0A, 16'h1111, 1'b0); chk("R1 foreign write err", {15'h0, g_err}, 16'h0);
        access(1'b0, 4'h6, 8'h0A, 16'h0, 1'b0); chk("R1 vector unchanged", g_data, 16'hC0DE);

        // R6: flag port
        access(1'b1, 4'h6, 8'h09, 16'h0015, 1'b0);
        chk("R6 flag strobe", {15'h0, g_evwr}, 16'h1);
        chk("R6 flag data", g_evdata, 16'h0015);
        access(1'b1, 4'h6, 8'h09, 16'h0020, 1'b0);
        chk("R7 flag reserved err", {15'h0, g_err}, 16'h1);
        chk("R6 no strobe on refusal", {15'h0, g_evwr}, 16'h0);

        // R5: status is live
        st_monitor = 1'b1;
        access(1'b0, 4'h6, 8'h04, 16'h0, 1'b0); chk("R5 live status", g_data, 16'h001B);

        // R9: gating
        st_enabled = 1'b0;
        access(1'b0, 4'h6, 8'h00, 16'h0, 1'b0); chk("R9 disabled read", {15'h0, g_valid}, 16'h0);
        access(1'b0, 4'h6, 8'h00, 16'h0, 1'b1); chk("R9 disabled sysmsg", g_data, 16'h0006);
        st_enabled = 1'b1; st_shutdown = 1'b1;
        access(1'b1, 4'h6, 8'h0A, 16'h2222, 1'b0); chk("R9 shutdown write", {15'h0, g_err}, 16'h0);
        access(1'b0, 4'h6, 8'h0A, 16'h0, 1'b1); chk("R9 vector unchanged", g_data, 16'hC0DE);
        st_shutdown = 1'b0;

        // R2: response lasts exactly one cycle
        access(1'b0, 4'h6, 8'h02, 16'h0, 1'b0);
        @(posedge clk); #1;
        chk("R2 valid single cycle", {15'h0, rd_valid}, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule